// File: doc/BRIEF.md
# Fair Tree Arbiter with Saturating Count

This block shares a small pool of converter slots among a large set of requesters. Once per reference cycle it takes a request vector of `N_REQ` bits, finds how many requesters are active, and hands each slot to at most one requester. If fewer requesters are active than there are slots, every active requester gets a slot. If more are active, each slot is filled. The requesters are arranged as the leaves of a binary tree. Request counts move up the tree as saturating thermometer words. Slot grants then move down, and at every node a preference bit decides which branch picks first.

A free-running counter supplies the preference bits. The node at depth k follows counter bit k, so the root swaps its preferred side every cycle and deeper nodes swap less often. Over one full counter period, every leaf is at some point first in line. For each slot the block also returns the index of the requester that holds it. Each index bit records the branch taken at one depth of the tree, and the root decision is the most significant bit. The grant path is combinational from `req`; only the preference counter holds state.

Top module: `fair_tree_arbiter`

## Requirements
- R1: `slot_count` is a thermometer word. Bit k is high exactly when at least k+1 bits of `req` are high, so it saturates at `N_SLOT`. Bit 0 stands for slot 0.
- R2: Each requester's grant field `grant[i*N_SLOT +: N_SLOT]` has at most one bit high. The field can be non-zero only when `req[i]` is high.
- R3: Slot s is held by exactly one requester when `slot_count[s]` is high and by none when it is low. The number of granted requesters is therefore min(popcount(req), `N_SLOT`).
- R4: At every tree node, the slots passed down to the two branches together equal the slots arriving from above, and no slot goes to both branches. The preferred branch takes the lowest-numbered arriving slots, as many as its own saturated request count allows. The other branch takes the rest.
- R5: A node at depth k (the root is depth 0) prefers its left (lower-index) branch when bit k of the preference counter is 0 and its right branch when that bit is 1. The counter is `log2(N_REQ)` bits wide and advances by one on every clock edge out of reset. With every requester active, each requester therefore receives a slot within `N_REQ` consecutive cycles.
- R6: `slot_addr[s*log2(N_REQ) +: log2(N_REQ)]` is the index of the requester holding slot s, with the root branch decision as its most significant bit. It is zero when slot s is unused.
- R7: While `rst_n` is low the preference counter is held at zero, so every node prefers its left branch. With all requests high, requesters 0 to `N_SLOT`-1 then receive slots 0 to `N_SLOT`-1 in that order.
- R8: `N_REQ` must be a power of two of at least 2 and `N_SLOT` must be at least 1; other values stop elaboration.

Slot encoding: within a requester's grant field, bit s set means slot s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset of the preference counter |
| req | input | N_REQ | One request bit per requester |
| slot_count | output | N_SLOT | Saturated thermometer count of active requests |
| grant | output | N_REQ*N_SLOT | Per-requester one-hot slot field, requester i at bits i*N_SLOT upward |
| slot_addr | output | N_SLOT*log2(N_REQ) | Per-slot requester index, slot s at bits s*log2(N_REQ) upward |

## Verification
The only state in the block is the preference counter. A wrong counter value would not change which slots are used or how many, but it would move grants between requesters in the same cycle. Every grant pattern is therefore compared bit for bit against a reference that derives preference from its own count of cycles since reset. A fault in a node's split logic shows up at once on `grant` and `slot_addr` for the request pattern that reaches that node. A fault in the count path shows up on `slot_count`, in the same combinational settling window.

// File: rtl/arb_tree_pkg.sv
package arb_tree_pkg;

   // true when v is a power of two and at least 2
   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // depth of heap node h (root h=1 sits at depth 0)
   function automatic int heap_depth(input int h);
      int d;
      int t;
      d = 0;
      t = h;
      while (t > 1) begin
         t = t / 2;
         d = d + 1;
      end
      return d;
   endfunction

endpackage

// File: rtl/arb_prio_ctr.sv
module arb_prio_ctr #(
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] prio
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio <= '0;
      else        prio <= prio + WIDTH'(1);
   end

endmodule

// File: rtl/arb_split_node.sv
module arb_split_node #(
   parameter int N_SLOT  = 4,
   parameter int AW      = 5,
   parameter int BIT_POS = 4
) (
   input  logic                 prio,
   input  logic [N_SLOT-1:0]    cnt_l,
   input  logic [N_SLOT-1:0]    cnt_r,
   output logic [N_SLOT-1:0]    cnt_o,
   input  logic [N_SLOT-1:0]    g_in,
   output logic [N_SLOT-1:0]    g_l,
   output logic [N_SLOT-1:0]    g_r,
   input  logic [N_SLOT*AW-1:0] a_l,
   input  logic [N_SLOT*AW-1:0] a_r,
   output logic [N_SLOT*AW-1:0] a_o
);

   localparam int CW = $clog2(N_SLOT + 1) + 1;
   localparam logic [AW-1:0] DIR_R = AW'(1) << BIT_POS;

   logic [CW-1:0]     n_l;
   logic [CW-1:0]     n_r;
   logic [CW-1:0]     n_sum;
   logic [CW-1:0]     n_pref;
   logic [CW-1:0]     taken;
   logic [N_SLOT-1:0] g_p;
   logic [N_SLOT-1:0] g_o;

   // saturated thermometer sum of both branches
   always_comb begin
      n_l   = CW'($countones(cnt_l));
      n_r   = CW'($countones(cnt_r));
      n_sum = n_l + n_r;
      for (int k = 0; k < N_SLOT; k++) begin
         cnt_o[k] = (n_sum > CW'(k));
      end
   end

   // preferred branch takes lowest slots up to its own count
   always_comb begin
      n_pref = prio ? n_r : n_l;
      taken  = '0;
      g_p    = '0;
      g_o    = '0;
      for (int s = 0; s < N_SLOT; s++) begin
         if (g_in[s]) begin
            if (taken < n_pref) begin
               g_p[s] = 1'b1;
               taken  = taken + CW'(1);
            end else begin
               g_o[s] = 1'b1;
            end
         end
      end
   end

   assign g_l = prio ? g_o : g_p;
   assign g_r = prio ? g_p : g_o;

   // address: the branch decision at this depth lands on bit BIT_POS
   always_comb begin
      a_o = '0;
      for (int s = 0; s < N_SLOT; s++) begin
         if (g_l[s])      a_o[s*AW +: AW] = a_l[s*AW +: AW];
         else if (g_r[s]) a_o[s*AW +: AW] = a_r[s*AW +: AW] | DIR_R;
      end
   end

endmodule

// File: rtl/fair_tree_arbiter.sv
module fair_tree_arbiter
   import arb_tree_pkg::*;
#(
   parameter int N_REQ  = 32,
   parameter int N_SLOT = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [N_REQ-1:0]                    req,
   output logic [N_SLOT-1:0]                   slot_count,
   output logic [N_REQ*N_SLOT-1:0]             grant,
   output logic [N_SLOT*$clog2(N_REQ)-1:0]     slot_addr
);

   localparam int AW = $clog2(N_REQ);
   localparam int NH = 2 * N_REQ;

   // elaboration checks, R8
   if (!is_pow2(N_REQ)) begin : g_bad_nreq
      $error("N_REQ must be a power of two of at least 2");
   end
   if (N_SLOT < 1) begin : g_bad_nslot
      $error("N_SLOT must be at least 1");
   end

   logic [AW-1:0]        prio;
   logic [N_SLOT-1:0]    h_cnt [1:NH-1];
   logic [N_SLOT-1:0]    h_g   [1:NH-1];
   logic [N_SLOT*AW-1:0] h_a   [1:NH-1];

   arb_prio_ctr #(.WIDTH(AW)) i_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .prio  (prio)
   );

   // leaves sit at heap index N_REQ + i
   for (genvar i = 0; i < N_REQ; i++) begin : g_leaf
      assign h_cnt[N_REQ+i]            = N_SLOT'(req[i]);
      assign h_a[N_REQ+i]              = '0;
      assign grant[i*N_SLOT +: N_SLOT] = h_g[N_REQ+i];
   end

   // inner nodes: children of h are 2h and 2h+1
   for (genvar h = 1; h < N_REQ; h++) begin : g_node
      localparam int DEPTH = heap_depth(h);
      arb_split_node #(
         .N_SLOT  (N_SLOT),
         .AW      (AW),
         .BIT_POS (AW - 1 - DEPTH)
      ) i_node (
         .prio  (prio[DEPTH]),
         .cnt_l (h_cnt[2*h]),
         .cnt_r (h_cnt[2*h+1]),
         .cnt_o (h_cnt[h]),
         .g_in  (h_g[h]),
         .g_l   (h_g[2*h]),
         .g_r   (h_g[2*h+1]),
         .a_l   (h_a[2*h]),
         .a_r   (h_a[2*h+1]),
         .a_o   (h_a[h])
      );

      AST_SPLIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(h_g[2*h]) + $countones(h_g[2*h+1]) == $countones(h_g[h]))
         && ((h_g[2*h] & h_g[2*h+1]) == '0)); // R4
   end

   // root: every counted slot is offered downwards
   assign h_g[1]     = h_cnt[1];
   assign slot_count = h_cnt[1];
   assign slot_addr  = h_a[1];

   // slot columns for the ownership checks
   logic [N_REQ-1:0] slot_col [N_SLOT];
   always_comb begin
      for (int s = 0; s < N_SLOT; s++) begin
         for (int i = 0; i < N_REQ; i++) begin
            slot_col[s][i] = grant[i*N_SLOT + s];
         end
      end
   end

   for (genvar k = 0; k < N_SLOT; k++) begin : g_slot_chk
      AST_COUNT_THERM: assert property (@(posedge clk) disable iff (!rst_n)
         slot_count[k] == ($countones(req) > k)); // R1
      AST_SLOT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(slot_col[k]) == int'(slot_count[k])); // R3
      AST_ADDR_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
         slot_count[k] |-> grant[int'(slot_addr[k*AW +: AW])*N_SLOT + k]); // R6
   end

   for (genvar i = 0; i < N_REQ; i++) begin : g_req_chk
      AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(grant[i*N_SLOT +: N_SLOT])
         && ((grant[i*N_SLOT +: N_SLOT] == '0) || req[i])); // R2
   end

endmodule

// File: tb/test_fair_tree_arbiter.sv
module test_fair_tree_arbiter;

   localparam int N    = 32;
   localparam int S    = 4;
   localparam int AW   = $clog2(N);
   localparam int CLK_P = 10;
   localparam int NTBL = 11;

   localparam logic [N-1:0] TBL_REQ [NTBL] = '{
      32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 32'h0000_0003,
      32'h0001_0001, 32'h0000_0007, 32'h0000_000F, 32'h0000_001F,
      32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h80F0_0001
   };
   localparam int TBL_CNT [NTBL] = '{0, 1, 1, 2, 2, 3, 4, 4, 4, 4, 4};

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [N-1:0]        req = '0;
   logic [S-1:0]        slot_count;
   logic [N*S-1:0]      grant;
   logic [S*AW-1:0]     slot_addr;

   int n_chk = 0;
   int n_fail = 0;
   int pcm = 0;
   bit done = 1'b0;

   fair_tree_arbiter #(.N_REQ(N), .N_SLOT(S)) i_fair_tree_arbiter (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .slot_count (slot_count),
      .grant      (grant),
      .slot_addr  (slot_addr)
   );

   always #(CLK_P/2) clk = ~clk;

   // cycles since reset, kept by the bench
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcm <= 0;
      else        pcm <= pcm + 1;
   end

   task automatic cmp(input string rq, input logic [N*S-1:0] act, input logic [N*S-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // behavioural reference of the slot assignment
   task automatic ref_model(input logic [N-1:0] r, input int pc,
                            output logic [S-1:0] ec, output logic [N*S-1:0] eg,
                            output logic [S*AW-1:0] ea);
      int c [1:2*N-1];
      int g [1:2*N-1];
      for (int i = 0; i < N; i++) c[N+i] = int'(r[i]);
      for (int h = N - 1; h >= 1; h--) begin
         c[h] = c[2*h] + c[2*h+1];
         if (c[h] > S) c[h] = S;
      end
      g[1] = (1 << c[1]) - 1;
      ec = S'(g[1]);
      for (int h = 1; h < N; h++) begin
         int lv, t, pf, ot, q;
         lv = 0;
         t = h;
         while (t > 1) begin t = t / 2; lv++; end
         pf = ((pc >> lv) & 1) != 0 ? 2*h + 1 : 2*h;
         ot = ((pc >> lv) & 1) != 0 ? 2*h : 2*h + 1;
         q = c[pf];
         g[pf] = 0;
         g[ot] = 0;
         for (int s = 0; s < S; s++) begin
            if (((g[h] >> s) & 1) != 0) begin
               if (q > 0) begin g[pf] |= (1 << s); q--; end
               else g[ot] |= (1 << s);
            end
         end
      end
      eg = '0;
      ea = '0;
      for (int i = 0; i < N; i++) begin
         eg[i*S +: S] = S'(g[N+i]);
         for (int s = 0; s < S; s++) begin
            if (((g[N+i] >> s) & 1) != 0) ea[s*AW +: AW] = AW'(i);
         end
      end
   endtask

   task automatic check_all(input string tag);
      logic [S-1:0]    ec;
      logic [N*S-1:0]  eg;
      logic [S*AW-1:0] ea;
      ref_model(req, pcm % N, ec, eg, ea);
      cmp({tag, " R1 count"}, (N*S)'(slot_count), (N*S)'(ec));
      cmp({tag, " R2 R3 R4 R5 grant"}, grant, eg);
      cmp({tag, " R6 addr"}, (N*S)'(slot_addr), (N*S)'(ea));
   endtask

   task automatic apply(input logic [N-1:0] v, input string tag);
      @(negedge clk);
      req = v;
      #1;
      check_all(tag);
   endtask

   initial begin
      logic [N-1:0] hit;
      // R7: in reset, all left preferred, lowest four take slots in order
      req = '1;
      #(CLK_P*3 + 1);
      cmp("R7 reset count", (N*S)'(slot_count), (N*S)'(4'hF));
      cmp("R7 reset grant", grant, (N*S)'(128'h8421));
      cmp("R7 reset addr", (N*S)'(slot_addr), (N*S)'({5'd3, 5'd2, 5'd1, 5'd0}));
      @(negedge clk);
      rst_n = 1'b1;

      // table walk
      for (int t = 0; t < NTBL; t++) begin
         apply(TBL_REQ[t], "table");
         cmp("R1 R3 table popcount", (N*S)'(slot_count), (N*S)'((1 << TBL_CNT[t]) - 1));
      end

      // random dense and sparse patterns
      for (int t = 0; t < 1500; t++) begin
         logic [N-1:0] v;
         v = $urandom;
         if (t % 3 == 1) v = v & $urandom & $urandom;
         if (t % 3 == 2) v = v & $urandom & $urandom & $urandom;
         apply(v, "random");
      end

      // R5: all requesting, each requester served within N cycles
      hit = '0;
      for (int t = 0; t < N; t++) begin
         apply('1, "R5 rotate");
         for (int i = 0; i < N; i++) if (grant[i*S +: S] != '0) hit[i] = 1'b1;
      end
      cmp("R5 every requester served", (N*S)'(hit), (N*S)'({N{1'b1}}));

      // reset mid-run restores left preference
      @(negedge clk);
      rst_n = 1'b0;
      req = 32'hF000_000F;
      #1;
      cmp("R7 mid-run reset grant", grant, (N*S)'(128'h8421));
      @(negedge clk);
      rst_n = 1'b1;
      apply(32'hF000_000F, "post reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P*150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule